// File: doc/BRIEF.md
# RISC instruction field decoder

This block is the combinational decode stage for a subset of a 32-bit fixed-length RISC instruction set with a big-endian bit layout. It takes one raw instruction word and an endian select. It returns everything the issue logic needs to steer operands:
- a micro-op class;
- three general-register read selects and one write select, each with an enable;
- condition-register field selects for three reads and one write;
- a special-register read request;
- a 64-bit expanded immediate;
- the memory access length;
- the update, record, link and absolute flags;
- the pass-through rotate and branch-condition fields.

The supported families are:
- add, and and or in register form, plus an indexed word load and an indexed word store;
- add-immediate, add-immediate-shifted, and-immediate-record, or-immediate and or-immediate-shifted;
- word, halfword and byte loads and stores, with and without update;
- register compare and the three 32-bit rotate-with-mask forms;
- relative branch, conditional branch, branch to link, branch to count, and condition-bit and.

Any other encoding is reported as illegal and every enable is cleared. Bit numbering below is LSB = bit 0. The major opcode is in bits 31..26. The extended opcode of majors 19 and 31 is in bits 10..1. RT/RS is bits 25..21, RA is bits 20..16 and RB is bits 15..11.

Top module: `risc_field_decoder`

## Requirements
- R1: `uop` encodes the class as ILLEGAL=0, NOP=1, ADD=2, AND=3, OR=4, LOAD=5, STORE=6, CMP=7, ROT=8, BRANCH=9, CROP=10. The supported words are decoded as follows:
  - major 31 with extended 266 (add), 28 (and), 444 (or), 23 (indexed word load), 151 (indexed word store) or 0 (compare);
  - majors 14 and 15 (add-immediate) and 28, 24 and 25 (and/or immediate);
  - majors 32 to 41, 44 and 45 (loads and stores);
  - majors 20, 21 and 23 (rotates);
  - majors 18 and 16 (branches);
  - major 19 with extended 16, 528 or 257.

  Every other word gives `uop`=0 and `illegal`=1, with all enables, flags, `mem_len`, `imm` and the field outputs at 0.
- R2: With `little_endian`=1 the four bytes of `insn_in` are reversed before decoding, so the swapped word decodes exactly as the unswapped word does with `little_endian`=0.
- R3: The exact word 0x60000000 decodes as NOP with every enable clear. Any other major-24 word decodes as OR.
- R4: Add, add-immediate and all loads write RT and read RA on port 1. The register-form add and the indexed load also read RB on port 2.
- R5: Stores read RS on port 3 and RA on port 1, and the indexed store also reads RB on port 2. Stores never enable the write port.
- R6: Logical ops (register and immediate forms) and rotates write RA and read RS on port 3. Register-form logical ops and the shift-by-register rotate (major 23) read RB on port 2. The insert rotate (major 20) reads RA on port 1.
- R7: `imm` is formed from bits 15..0 (UI) in one of four modes:
  - zero-extended, for and/or immediate;
  - UI placed in bits 31..16 with zeros above, for or-immediate-shifted;
  - sign-extended from bit 15, for add-immediate and D-form loads and stores;
  - UI shifted left 16 and sign-extended from bit 31, for add-immediate-shifted.
- R8: `mem_len` is 4 for word, 2 for halfword and 1 for byte loads and stores, and 0 otherwise. `update` is 1 only for the odd majors 33, 35, 37, 39, 41 and 45.
- R9: `rec` equals bit 0 for the register-form add/and/or and for the rotates. It is 1 for and-immediate-record and 0 for every other form.
- R10: For major 18, `imm` is the sign-extended word-aligned LI displacement (bits 25..2 with two zero bits appended). For major 16, it is the same treatment of BD (bits 15..2). For both, `link` is bit 0 and `absolute` is bit 1.
- R11: Branch to link (19/16) and branch to count (19/528) set `spr_rd_en`, with `spr_rd_sel`=0 for the link register and 1 for the count register, and `link` set from bit 0. All three conditional branches pass BO (bits 25..21) to `br_bo` and BI (bits 20..16) to `br_bi`.
- R12: The condition-register field selects are as follows:
  - condition-bit and reads field BA/4 (bits 20..18) on CR port 1 and BB/4 (bits 15..13) on CR port 2. It reads field BT/4 (bits 25..23) on CR port 3 and also writes BT/4.
  - The conditional branches read field BI/4 on CR port 1.
  - Compare writes CR field BF (bits 25..23) and reads RA on port 1 and RB on port 2.
- R13: Rotates output SH (bits 15..11), MB (bits 10..6) and ME (bits 5..1). These fields read 0 for all other classes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_in | input | 32 | Raw instruction word |
| little_endian | input | 1 | 1: reverse the byte order of insn_in before decode |
| uop | output | 4 | Micro-op class |
| illegal | output | 1 | Encoding outside the supported subset |
| gpr_wr_en | output | 1 | General-register write enable |
| gpr_wr_sel | output | 5 | Register written |
| gpr_rd1_en | output | 1 | Read port 1 enable |
| gpr_rd1_sel | output | 5 | Read port 1 register |
| gpr_rd2_en | output | 1 | Read port 2 enable |
| gpr_rd2_sel | output | 5 | Read port 2 register |
| gpr_rd3_en | output | 1 | Read port 3 enable |
| gpr_rd3_sel | output | 5 | Read port 3 register |
| cr_wr_en | output | 1 | CR field write enable |
| cr_wr_sel | output | 3 | CR field written |
| cr_rd1_en | output | 1 | CR read 1 enable |
| cr_rd1_sel | output | 3 | CR read 1 field |
| cr_rd2_en | output | 1 | CR read 2 enable |
| cr_rd2_sel | output | 3 | CR read 2 field |
| cr_rd3_en | output | 1 | CR read 3 enable |
| cr_rd3_sel | output | 3 | CR read 3 field |
| spr_rd_en | output | 1 | Special-register read request |
| spr_rd_sel | output | 1 | 0 link register, 1 count register |
| imm | output | 64 | Expanded immediate or branch displacement |
| mem_len | output | 3 | Access length in bytes |
| update | output | 1 | Update form of load/store |
| rec | output | 1 | Record result into CR |
| link | output | 1 | Save return address |
| absolute | output | 1 | Absolute branch target |
| rot_sh | output | 5 | Rotate amount field |
| rot_mb | output | 5 | Mask begin field |
| rot_me | output | 5 | Mask end field |
| br_bo | output | 5 | Branch options field |
| br_bi | output | 5 | Condition bit index |

## Verification
Every family is driven with random register numbers, immediates and field values. The immediate patterns include values with bit 15 set and clear, so the four expansion modes give different upper halves. Each word is applied in both byte orders, which separates a missing or wrong byte swap from a field-extraction error.

A set of fixed words covers the boundaries:
- the exact no-op word and its nearest or-immediate neighbours;
- majors just outside the supported ranges (42, 43, 46, 30, 58, 62);
- unlisted extended opcodes under majors 19 and 31.

These tell a correct illegal path apart from one that leaves stale enables set.

// File: rtl/risc_field_decoder.sv
module risc_field_decoder (
  input  logic [31:0] insn_in,
  input  logic        little_endian,
  output logic [3:0]  uop,
  output logic        illegal,
  output logic        gpr_wr_en,
  output logic [4:0]  gpr_wr_sel,
  output logic        gpr_rd1_en,
  output logic [4:0]  gpr_rd1_sel,
  output logic        gpr_rd2_en,
  output logic [4:0]  gpr_rd2_sel,
  output logic        gpr_rd3_en,
  output logic [4:0]  gpr_rd3_sel,
  output logic        cr_wr_en,
  output logic [2:0]  cr_wr_sel,
  output logic        cr_rd1_en,
  output logic [2:0]  cr_rd1_sel,
  output logic        cr_rd2_en,
  output logic [2:0]  cr_rd2_sel,
  output logic        cr_rd3_en,
  output logic [2:0]  cr_rd3_sel,
  output logic        spr_rd_en,
  output logic        spr_rd_sel,
  output logic [63:0] imm,
  output logic [2:0]  mem_len,
  output logic        update,
  output logic        rec,
  output logic        link,
  output logic        absolute,
  output logic [4:0]  rot_sh,
  output logic [4:0]  rot_mb,
  output logic [4:0]  rot_me,
  output logic [4:0]  br_bo,
  output logic [4:0]  br_bi
);
  localparam logic [3:0] U_ILL = 4'd0, U_NOP = 4'd1, U_ADD = 4'd2, U_AND = 4'd3,
                         U_OR = 4'd4, U_LD = 4'd5, U_ST = 4'd6, U_CMP = 4'd7,
                         U_ROT = 4'd8, U_BR = 4'd9, U_CR = 4'd10;

  typedef enum logic [2:0] {IM_NONE, IM_U, IM_UH, IM_S, IM_SH, IM_LI, IM_BD} imode_t;

  logic [31:0] w;
  logic [5:0]  opc;
  logic [9:0]  xo;
  logic [4:0]  f_rt, f_ra, f_rb;
  imode_t      imode;

  assign w    = little_endian ? {insn_in[7:0], insn_in[15:8], insn_in[23:16], insn_in[31:24]}
                              : insn_in;
  assign opc  = w[31:26];
  assign xo   = w[10:1];
  assign f_rt = w[25:21];
  assign f_ra = w[20:16];
  assign f_rb = w[15:11];

  always_comb begin
    uop = U_ILL; illegal = 1'b0; imode = IM_NONE;
    gpr_wr_en = 1'b0;  gpr_wr_sel = '0;
    gpr_rd1_en = 1'b0; gpr_rd1_sel = '0;
    gpr_rd2_en = 1'b0; gpr_rd2_sel = '0;
    gpr_rd3_en = 1'b0; gpr_rd3_sel = '0;
    cr_wr_en = 1'b0;  cr_wr_sel = '0;
    cr_rd1_en = 1'b0; cr_rd1_sel = '0;
    cr_rd2_en = 1'b0; cr_rd2_sel = '0;
    cr_rd3_en = 1'b0; cr_rd3_sel = '0;
    spr_rd_en = 1'b0; spr_rd_sel = 1'b0;
    mem_len = '0; update = 1'b0; rec = 1'b0; link = 1'b0; absolute = 1'b0;
    rot_sh = '0; rot_mb = '0; rot_me = '0; br_bo = '0; br_bi = '0;
    case (opc)
      6'd31: case (xo)
        10'd266: begin
          uop = U_ADD; gpr_wr_en = 1'b1; gpr_wr_sel = f_rt;
          gpr_rd1_en = 1'b1; gpr_rd1_sel = f_ra; gpr_rd2_en = 1'b1; gpr_rd2_sel = f_rb;
          rec = w[0];
        end
        10'd28, 10'd444: begin
          uop = (xo == 10'd28) ? U_AND : U_OR;
          gpr_wr_en = 1'b1; gpr_wr_sel = f_ra;
          gpr_rd3_en = 1'b1; gpr_rd3_sel = f_rt; gpr_rd2_en = 1'b1; gpr_rd2_sel = f_rb;
          rec = w[0];
        end
        10'd23: begin
          uop = U_LD; mem_len = 3'd4; gpr_wr_en = 1'b1; gpr_wr_sel = f_rt;
          gpr_rd1_en = 1'b1; gpr_rd1_sel = f_ra; gpr_rd2_en = 1'b1; gpr_rd2_sel = f_rb;
        end
        10'd151: begin
          uop = U_ST; mem_len = 3'd4; gpr_rd3_en = 1'b1; gpr_rd3_sel = f_rt;
          gpr_rd1_en = 1'b1; gpr_rd1_sel = f_ra; gpr_rd2_en = 1'b1; gpr_rd2_sel = f_rb;
        end
        10'd0: begin
          uop = U_CMP; cr_wr_en = 1'b1; cr_wr_sel = w[25:23];
          gpr_rd1_en = 1'b1; gpr_rd1_sel = f_ra; gpr_rd2_en = 1'b1; gpr_rd2_sel = f_rb;
        end
        default: illegal = 1'b1;
      endcase
      6'd14, 6'd15: begin
        uop = U_ADD; gpr_wr_en = 1'b1; gpr_wr_sel = f_rt;
        gpr_rd1_en = 1'b1; gpr_rd1_sel = f_ra;
        imode = opc[0] ? IM_SH : IM_S;
      end
      6'd28, 6'd24, 6'd25: begin
        if (w == 32'h6000_0000) uop = U_NOP;
        else begin
          uop = (opc == 6'd28) ? U_AND : U_OR;
          gpr_wr_en = 1'b1; gpr_wr_sel = f_ra; gpr_rd3_en = 1'b1; gpr_rd3_sel = f_rt;
          imode = (opc == 6'd25) ? IM_UH : IM_U;
          rec = (opc == 6'd28);
        end
      end
      6'd32, 6'd33, 6'd34, 6'd35, 6'd40, 6'd41,
      6'd36, 6'd37, 6'd38, 6'd39, 6'd44, 6'd45: begin
        gpr_rd1_en = 1'b1; gpr_rd1_sel = f_ra; imode = IM_S; update = opc[0];
        case (opc[3:1])
          3'd0, 3'd2: mem_len = 3'd4;
          3'd1, 3'd3: mem_len = 3'd1;
          default:    mem_len = 3'd2;
        endcase
        if (opc[2] && opc[3:1] != 3'd4) begin
          uop = U_ST; gpr_rd3_en = 1'b1; gpr_rd3_sel = f_rt;
        end else begin
          uop = U_LD; gpr_wr_en = 1'b1; gpr_wr_sel = f_rt;
        end
      end
      6'd20, 6'd21, 6'd23: begin
        uop = U_ROT; gpr_wr_en = 1'b1; gpr_wr_sel = f_ra;
        gpr_rd3_en = 1'b1; gpr_rd3_sel = f_rt;
        rot_sh = f_rb; rot_mb = w[10:6]; rot_me = w[5:1]; rec = w[0];
        if (opc == 6'd23) begin gpr_rd2_en = 1'b1; gpr_rd2_sel = f_rb; end
        if (opc == 6'd20) begin gpr_rd1_en = 1'b1; gpr_rd1_sel = f_ra; end
      end
      6'd18: begin
        uop = U_BR; imode = IM_LI; link = w[0]; absolute = w[1];
      end
      6'd16: begin
        uop = U_BR; imode = IM_BD; link = w[0]; absolute = w[1];
        br_bo = f_rt; br_bi = f_ra; cr_rd1_en = 1'b1; cr_rd1_sel = f_ra[4:2];
      end
      6'd19: case (xo)
        10'd16, 10'd528: begin
          uop = U_BR; link = w[0]; br_bo = f_rt; br_bi = f_ra;
          cr_rd1_en = 1'b1; cr_rd1_sel = f_ra[4:2];
          spr_rd_en = 1'b1; spr_rd_sel = (xo == 10'd528);
        end
        10'd257: begin
          uop = U_CR;
          cr_rd1_en = 1'b1; cr_rd1_sel = f_ra[4:2];
          cr_rd2_en = 1'b1; cr_rd2_sel = f_rb[4:2];
          cr_rd3_en = 1'b1; cr_rd3_sel = f_rt[4:2];
          cr_wr_en = 1'b1;  cr_wr_sel = f_rt[4:2];
        end
        default: illegal = 1'b1;
      endcase
      default: illegal = 1'b1;
    endcase

    case (imode)
      IM_U:    imm = {48'h0, w[15:0]};
      IM_UH:   imm = {32'h0, w[15:0], 16'h0};
      IM_S:    imm = {{48{w[15]}}, w[15:0]};
      IM_SH:   imm = {{32{w[15]}}, w[15:0], 16'h0};
      IM_LI:   imm = {{38{w[25]}}, w[25:2], 2'b00};
      IM_BD:   imm = {{48{w[15]}}, w[15:2], 2'b00};
      default: imm = '0;
    endcase

    p_illegal_quiet_r1: assert (!illegal || (uop == U_ILL && !gpr_wr_en && !cr_wr_en &&
                                !gpr_rd1_en && !gpr_rd2_en && !gpr_rd3_en && !spr_rd_en &&
                                imm == '0 && mem_len == '0))
      else $error("illegal word left outputs active");
    p_nop_word_r3: assert (w != 32'h6000_0000 || (uop == U_NOP && !gpr_wr_en && !gpr_rd3_en))
      else $error("no-op word not decoded as no-op");
    p_store_nowrite_r5: assert (uop != U_ST || (!gpr_wr_en && gpr_rd3_en))
      else $error("store routing broken");
    p_len_mem_r8: assert (((mem_len != '0) == (uop == U_LD || uop == U_ST)) &&
                          (!update || mem_len != '0))
      else $error("length or update outside memory ops");
    p_spr_branch_r11: assert (!spr_rd_en || uop == U_BR)
      else $error("special-register read outside branches");
    p_crwr_r12: assert (!cr_wr_en || uop == U_CMP || uop == U_CR)
      else $error("CR write from wrong class");
  end
endmodule

// File: tb/test_risc_field_decoder.sv
`timescale 1ns/1ps
module test_risc_field_decoder;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] insn;
  logic        le;
  logic [3:0]  uop;
  logic        illegal, gpr_wr_en, gpr_rd1_en, gpr_rd2_en, gpr_rd3_en;
  logic [4:0]  gpr_wr_sel, gpr_rd1_sel, gpr_rd2_sel, gpr_rd3_sel;
  logic        cr_wr_en, cr_rd1_en, cr_rd2_en, cr_rd3_en, spr_rd_en, spr_rd_sel;
  logic [2:0]  cr_wr_sel, cr_rd1_sel, cr_rd2_sel, cr_rd3_sel, mem_len;
  logic [63:0] imm;
  logic        update, rec, link, absolute;
  logic [4:0]  rot_sh, rot_mb, rot_me, br_bo, br_bi;

  risc_field_decoder i_risc_field_decoder (
    .insn_in(insn), .little_endian(le), .uop(uop), .illegal(illegal),
    .gpr_wr_en(gpr_wr_en), .gpr_wr_sel(gpr_wr_sel),
    .gpr_rd1_en(gpr_rd1_en), .gpr_rd1_sel(gpr_rd1_sel),
    .gpr_rd2_en(gpr_rd2_en), .gpr_rd2_sel(gpr_rd2_sel),
    .gpr_rd3_en(gpr_rd3_en), .gpr_rd3_sel(gpr_rd3_sel),
    .cr_wr_en(cr_wr_en), .cr_wr_sel(cr_wr_sel),
    .cr_rd1_en(cr_rd1_en), .cr_rd1_sel(cr_rd1_sel),
    .cr_rd2_en(cr_rd2_en), .cr_rd2_sel(cr_rd2_sel),
    .cr_rd3_en(cr_rd3_en), .cr_rd3_sel(cr_rd3_sel),
    .spr_rd_en(spr_rd_en), .spr_rd_sel(spr_rd_sel), .imm(imm), .mem_len(mem_len),
    .update(update), .rec(rec), .link(link), .absolute(absolute),
    .rot_sh(rot_sh), .rot_mb(rot_mb), .rot_me(rot_me), .br_bo(br_bo), .br_bi(br_bi));

  int vectors = 0;
  int miscompares = 0;

  logic [3:0]  e_uop;
  logic        e_ill, e_wr_en, e_r1_en, e_r2_en, e_r3_en;
  logic [4:0]  e_wr, e_r1, e_r2, e_r3;
  logic        e_cw_en, e_c1_en, e_c2_en, e_c3_en, e_spr_en, e_spr;
  logic [2:0]  e_cw, e_c1, e_c2, e_c3, e_len;
  logic [63:0] e_imm;
  logic        e_upd, e_rec, e_lk, e_aa;
  logic [4:0]  e_sh, e_mb, e_me, e_bo, e_bi;

  task automatic clr();
    e_uop = 0; e_ill = 0; e_wr_en = 0; e_r1_en = 0; e_r2_en = 0; e_r3_en = 0;
    e_wr = 0; e_r1 = 0; e_r2 = 0; e_r3 = 0;
    e_cw_en = 0; e_c1_en = 0; e_c2_en = 0; e_c3_en = 0; e_spr_en = 0; e_spr = 0;
    e_cw = 0; e_c1 = 0; e_c2 = 0; e_c3 = 0; e_len = 0; e_imm = 0;
    e_upd = 0; e_rec = 0; e_lk = 0; e_aa = 0;
    e_sh = 0; e_mb = 0; e_me = 0; e_bo = 0; e_bi = 0;
  endtask

  task automatic apply(input logic [31:0] word, input string tag);
    logic [159:0] act, exp;
    for (int m = 0; m < 2; m++) begin
      @(posedge clk); #1;
      le = m[0];
      insn = m[0] ? {word[7:0], word[15:8], word[23:16], word[31:24]} : word;
      @(negedge clk);
      act = {uop, illegal, gpr_wr_en, gpr_wr_sel, gpr_rd1_en, gpr_rd1_sel, gpr_rd2_en,
             gpr_rd2_sel, gpr_rd3_en, gpr_rd3_sel, cr_wr_en, cr_wr_sel, cr_rd1_en, cr_rd1_sel,
             cr_rd2_en, cr_rd2_sel, cr_rd3_en, cr_rd3_sel, spr_rd_en, spr_rd_sel, imm, mem_len,
             update, rec, link, absolute, rot_sh, rot_mb, rot_me, br_bo, br_bi};
      exp = {e_uop, e_ill, e_wr_en, e_wr, e_r1_en, e_r1, e_r2_en, e_r2, e_r3_en, e_r3,
             e_cw_en, e_cw, e_c1_en, e_c1, e_c2_en, e_c2, e_c3_en, e_c3, e_spr_en, e_spr,
             e_imm, e_len, e_upd, e_rec, e_lk, e_aa, e_sh, e_mb, e_me, e_bo, e_bi};
      vectors++;
      if (act !== exp) begin
        miscompares++;
        $display("FAIL %s (R2 when le=1) word=%h le=%0d actual=%h expected=%h",
                 tag, word, m, act, exp);
      end
    end
  endtask

  function automatic logic [63:0] sx(input longint v);
    return 64'(v);
  endfunction

  int ld_opc [12] = '{32, 33, 34, 35, 36, 37, 38, 39, 40, 41, 44, 45};
  int ld_len [12] = '{4, 4, 1, 1, 4, 4, 1, 1, 2, 2, 2, 2};
  int ld_st  [12] = '{0, 0, 0, 0, 1, 1, 1, 1, 0, 0, 1, 1};
  int x31_xo [6]  = '{266, 28, 444, 23, 151, 0};

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    insn = 0; le = 0;
    // R1 baseline: all-zero word is major 0, illegal
    clr(); e_ill = 1; apply(32'h0, "R1 zero word");

    // R3 no-op and its neighbours
    clr(); e_uop = 1; apply(32'h6000_0000, "R3 nop");
    clr(); e_uop = 4; e_wr_en = 1; e_r3_en = 1; e_imm = 64'd1;
    apply(32'h6000_0001, "R3 ori imm 1");
    clr(); e_uop = 4; e_wr_en = 1; e_wr = 5'd1; e_r3_en = 1;
    apply(32'h6001_0000, "R3 ori ra 1");

    // R1 illegal boundaries
    for (int k = 0; k < 9; k++) begin
      logic [31:0] wd;
      case (k)
        0: wd = {6'd42, 26'h155_5555};
        1: wd = {6'd43, 26'h0};
        2: wd = {6'd46, 26'h3ff_ffff};
        3: wd = {6'd30, 26'h12_3456};
        4: wd = {6'd58, 26'h1};
        5: wd = {6'd62, 26'h2};
        6: wd = {6'd31, 15'h1234, 10'd1, 1'b0};
        7: wd = {6'd19, 15'h1234, 10'd0, 1'b1};
        default: wd = {6'd31, 15'h7fff, 10'd267, 1'b1};
      endcase
      clr(); e_ill = 1; apply(wd, "R1 illegal");
    end

    for (int i = 0; i < 24; i++) begin
      logic [4:0] rt, ra, rb, f4, f5;
      logic [15:0] ui;
      logic rc;
      int sel;
      rt = 5'($urandom); ra = 5'($urandom); rb = 5'($urandom);
      f4 = 5'($urandom); f5 = 5'($urandom);
      ui = 16'($urandom);
      if (i[0]) ui[15] = ~ui[15];
      rc = 1'($urandom);

      // register-form families (R4 R5 R6 R9 R12)
      sel = i % 6;
      clr();
      case (sel)
        0: begin e_uop = 2; e_wr_en = 1; e_wr = rt; e_r1_en = 1; e_r1 = ra;
                 e_r2_en = 1; e_r2 = rb; e_rec = rc; end
        1, 2: begin e_uop = (sel == 1) ? 3 : 4; e_wr_en = 1; e_wr = ra; e_r3_en = 1; e_r3 = rt;
                 e_r2_en = 1; e_r2 = rb; e_rec = rc; end
        3: begin e_uop = 5; e_len = 4; e_wr_en = 1; e_wr = rt; e_r1_en = 1; e_r1 = ra;
                 e_r2_en = 1; e_r2 = rb; end
        4: begin e_uop = 6; e_len = 4; e_r3_en = 1; e_r3 = rt; e_r1_en = 1; e_r1 = ra;
                 e_r2_en = 1; e_r2 = rb; end
        default: begin e_uop = 7; e_cw_en = 1; e_cw = rt[4:2]; e_r1_en = 1; e_r1 = ra;
                 e_r2_en = 1; e_r2 = rb; end
      endcase
      if (sel == 5) apply({6'd31, rt[4:2], 2'b00, ra, rb, 10'd0, 1'b0}, "R12 cmp");
      else apply({6'd31, rt, ra, rb, 10'(x31_xo[sel]), rc}, "R4 R5 R6 R9 x-form");

      // immediate families (R7 R6 R9)
      sel = i % 5;
      clr();
      case (sel)
        0: begin e_uop = 2; e_wr_en = 1; e_wr = rt; e_r1_en = 1; e_r1 = ra;
                 e_imm = sx(ui[15] ? longint'(ui) - 65536 : longint'(ui)); end
        1: begin e_uop = 2; e_wr_en = 1; e_wr = rt; e_r1_en = 1; e_r1 = ra;
                 e_imm = sx((longint'(ui) * 65536) - (ui[15] ? 64'sh1_0000_0000 : 0)); end
        2: begin e_uop = 3; e_wr_en = 1; e_wr = ra; e_r3_en = 1; e_r3 = rt; e_rec = 1;
                 e_imm = sx(longint'(ui)); end
        3: begin e_uop = 4; e_wr_en = 1; e_wr = ra; e_r3_en = 1; e_r3 = rt;
                 e_imm = sx(longint'(ui)); end
        default: begin e_uop = 4; e_wr_en = 1; e_wr = ra; e_r3_en = 1; e_r3 = rt;
                 e_imm = sx(longint'(ui) * 65536); end
      endcase
      case (sel)
        0: apply({6'd14, rt, ra, ui}, "R7 addi signed");
        1: apply({6'd15, rt, ra, ui}, "R7 addis signed-high");
        2: apply({6'd28, rt, ra, ui}, "R7 R9 andi. unsigned");
        3: begin
          if ({rt, ra, ui} == 26'h0) begin clr(); e_uop = 1; end
          apply({6'd24, rt, ra, ui}, "R7 ori unsigned");
        end
        default: apply({6'd25, rt, ra, ui}, "R7 oris unsigned-high");
      endcase

      // D-form memory (R8 R4 R5)
      for (int j = 0; j < 12; j++) begin
        clr();
        e_len = 3'(ld_len[j]); e_upd = ld_opc[j][0];
        e_r1_en = 1; e_r1 = ra;
        e_imm = sx(ui[15] ? longint'(ui) - 65536 : longint'(ui));
        if (ld_st[j] == 1) begin e_uop = 6; e_r3_en = 1; e_r3 = rt; end
        else begin e_uop = 5; e_wr_en = 1; e_wr = rt; end
        apply({6'(ld_opc[j]), rt, ra, ui}, "R8 load/store length update");
      end

      // rotates (R13 R6 R9)
      for (int j = 0; j < 3; j++) begin
        int op;
        op = (j == 0) ? 20 : (j == 1) ? 21 : 23;
        clr();
        e_uop = 8; e_wr_en = 1; e_wr = ra; e_r3_en = 1; e_r3 = rt;
        e_sh = rb; e_mb = f4; e_me = f5; e_rec = rc;
        if (op == 23) begin e_r2_en = 1; e_r2 = rb; end
        if (op == 20) begin e_r1_en = 1; e_r1 = ra; end
        apply({6'(op), rt, ra, rb, f4, f5, rc}, "R13 rotate fields");
      end

      // branches (R10 R11 R12)
      begin
        logic [23:0] li;
        logic [13:0] bd;
        logic aa, lk;
        li = 24'($urandom); bd = 14'($urandom); aa = 1'($urandom); lk = 1'($urandom);
        if (i[1]) begin li[23] = 1'b1; bd[13] = 1'b1; end
        clr(); e_uop = 9; e_aa = aa; e_lk = lk;
        e_imm = sx(longint'(li) * 4 - (li[23] ? 64'sh400_0000 : 0));
        apply({6'd18, li, aa, lk}, "R10 b displacement");
        clr(); e_uop = 9; e_aa = aa; e_lk = lk; e_bo = rt; e_bi = ra;
        e_c1_en = 1; e_c1 = 3'(ra / 4);
        e_imm = sx(longint'(bd) * 4 - (bd[13] ? 64'sh1_0000 : 0));
        apply({6'd16, rt, ra, bd, aa, lk}, "R10 R12 bc");
        clr(); e_uop = 9; e_lk = lk; e_bo = rt; e_bi = ra; e_c1_en = 1; e_c1 = 3'(ra / 4);
        e_spr_en = 1; e_spr = 0;
        apply({6'd19, rt, ra, 3'b0, rb[1:0], 10'd16, lk}, "R11 bclr");
        e_spr = 1;
        apply({6'd19, rt, ra, 3'b0, rb[1:0], 10'd528, lk}, "R11 bcctr");
      end

      // crand (R12)
      clr(); e_uop = 10;
      e_c1_en = 1; e_c1 = 3'(ra / 4); e_c2_en = 1; e_c2 = 3'(rb / 4);
      e_c3_en = 1; e_c3 = 3'(rt / 4); e_cw_en = 1; e_cw = 3'(rt / 4);
      apply({6'd19, rt, ra, rb, 10'd257, 1'b0}, "R12 crand");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule